// File: doc/BRIEF.md
# Serial Calibration Word Loader

This block loads 6-bit calibration words into a bank of eight holding registers, one per delay channel. The holding registers drive the calibration converters of the delay lines. An external controller sends each word one bit at a time on a slow serial clock, most significant bit first, while a shift enable is held high. It then drops the shift enable and raises a write strobe. On the next serial clock edge the word is copied into the register picked by a 3-bit channel address.

Shifting and committing are separate phases. The shifted word stays in the shift register while the shift enable is low, so one word can be committed to several channels in turn. The channel address must stay put from the first shift edge until one serial clock edge after the write strobe drops. The block watches this rule and raises a sticky error flag when the address moves inside that window. Everything runs on the serial clock, which typically runs at 1 to 10 MHz, and uses a synchronous active-low reset.

Top module: `cal_serial_loader`

## Requirements
- R1: On a clock edge with `rst_n` low, all eight calibration words, the shift register and `addr_err` become zero. A write made after reset, with no shift in between, stores 0.
- R2: The shift register changes only on edges where `shift_en` is high. Edges with `shift_en` low leave the held word unchanged, whatever `sdata` does.
- R3: On each edge with `shift_en` high, the shift register moves up one place and takes `sdata` into bit 0. After six such edges, the first bit sent sits in bit 5 and the last in bit 0.
- R4: On an edge with `wr_stb` high and `shift_en` low, the shift register contents are copied into word `chan_sel`. Word k sits at `cal_words[6k+5:6k]`. No other word changes.
- R5: On edges with `wr_stb` low, no calibration word changes.
- R6: On an edge with both `shift_en` and `wr_stb` high, the shift takes place and no word is written.
- R7: The shifted word stays available across any number of later writes. It can be committed to several channels without shifting again.
- R8: A check window opens on an edge with `shift_en` high. If `chan_sel` differs from its value at that opening edge on any later edge inside the window, `addr_err` is set.
- R9: Once set, `addr_err` stays high until a reset.
- R10: Address changes outside a window do not set `addr_err`. A write strobe that no shift preceded does not open a window.
- R11: The window closes on the first edge that samples `wr_stb` low after it was sampled high. The address is still checked on that closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sdata | input | 1 | Serial calibration data, MSB first |
| shift_en | input | 1 | Shift enable |
| wr_stb | input | 1 | Write strobe, commits the shifted word |
| chan_sel | input | 3 | Channel address of the target word |
| cal_words | output | 48 | Eight 6-bit calibration words, channel k at bits 6k+5:6k |
| addr_err | output | 1 | Sticky address-stability violation flag |

## Verification
The hardest case to reach is the edge of the check window. The address is still checked on the edge right after the write strobe drops, and it is free one edge later. The stimulus drives the strobe low and changes the address on that same edge, which must raise the flag. A second sequence changes the address only one edge later, which must leave the flag clear. A third sequence raises shift enable and the write strobe together, so that priority is seen as an untouched word followed by a shifted value on the next write.

// File: rtl/cal_ldr_pkg.sv
`timescale 1ns/1ps
package cal_ldr_pkg;

  // Address-stability window tracking
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,   // no sequence in progress
    WIN_OPEN  = 2'd1,   // shift seen, waiting for write strobe
    WIN_WROTE = 2'd2    // write strobe seen, waiting for it to drop
  } win_state_e;

endpackage

// File: rtl/cal_shifter.sv
`timescale 1ns/1ps
module cal_shifter #(
  parameter int unsigned WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdata,
  output logic [WORD_W-1:0] sr_q
);

  function automatic logic [WORD_W-1:0] shift_next(input logic [WORD_W-1:0] cur,
                                                   input logic              bit_in);
    return {cur[WORD_W-2:0], bit_in};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= shift_next(sr_q, sdata);
  end

  // R2
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));

  // R3
  sr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(sdata)) && (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0])));

endmodule

// File: rtl/cal_bank.sv
`timescale 1ns/1ps
module cal_bank #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned N_CH   = 8,
  localparam int unsigned AW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic                         wr_stb,
  input  logic [AW-1:0]                chan_sel,
  input  logic [WORD_W-1:0]            sr_in,
  output logic [N_CH-1:0][WORD_W-1:0]  words_q,
  output logic                         commit
);

  function automatic logic [N_CH-1:0] decode_sel(input logic [AW-1:0] a);
    logic [N_CH-1:0] oh;
    oh = '0;
    for (int k = 0; k < N_CH; k++) oh[k] = (a == AW'(k));
    return oh;
  endfunction

  logic [N_CH-1:0] sel_oh;
  logic [N_CH-1:0] wr_hit;

  // shift wins over a simultaneous write strobe
  assign commit = wr_stb & ~shift_en;
  assign sel_oh = decode_sel(chan_sel);

  for (genvar g = 0; g < N_CH; g++) begin : g_word
    assign wr_hit[g] = commit & sel_oh[g];

    always_ff @(posedge clk) begin
      if (!rst_n)         words_q[g] <= '0;
      else if (wr_hit[g]) words_q[g] <= sr_in;
    end

    // R4
    other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (chan_sel != AW'(g))) |=> $stable(words_q[g]));
  end

  // R4
  commit_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> words_q[$past(chan_sel)] == $past(sr_in));

  // R5
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(words_q));

  // R6
  shift_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(words_q));

endmodule

// File: rtl/cal_addr_guard.sv
`timescale 1ns/1ps
module cal_addr_guard
  import cal_ldr_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          wr_stb,
  input  logic [AW-1:0] chan_sel,
  output logic          in_window,
  output logic          addr_moved,
  output logic          addr_err
);

  win_state_e    state_q, state_d;
  logic [AW-1:0] ref_q;
  logic          reopen;

  assign in_window  = (state_q != WIN_IDLE);
  assign addr_moved = (chan_sel != ref_q);

  always_comb begin
    state_d = state_q;
    reopen  = 1'b0;
    unique case (state_q)
      WIN_IDLE: if (shift_en) begin
        state_d = WIN_OPEN;
        reopen  = 1'b1;
      end
      WIN_OPEN: if (wr_stb) state_d = WIN_WROTE;
      WIN_WROTE: if (!wr_stb) begin
        state_d = shift_en ? WIN_OPEN : WIN_IDLE;
        reopen  = shift_en;
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= WIN_IDLE;
      ref_q    <= '0;
      addr_err <= 1'b0;
    end else begin
      state_q <= state_d;
      if (reopen) ref_q <= chan_sel;
      if (in_window && addr_moved) addr_err <= 1'b1;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_window && !addr_err) |=> !addr_err);

  // R11
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_WROTE && !wr_stb && !shift_en) |=> !in_window);

endmodule

// File: rtl/cal_serial_loader.sv
`timescale 1ns/1ps
module cal_serial_loader #(
  parameter int unsigned WORD_W = 6,
  parameter int unsigned N_CH   = 8,
  localparam int unsigned AW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdata,
  input  logic                   shift_en,
  input  logic                   wr_stb,
  input  logic [AW-1:0]          chan_sel,
  output logic [N_CH*WORD_W-1:0] cal_words,
  output logic                   addr_err
);

  logic [WORD_W-1:0]           sr_q;
  logic [N_CH-1:0][WORD_W-1:0] words_q;
  logic                        commit;
  logic                        in_window;
  logic                        addr_moved;

  cal_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdata    (sdata),
    .sr_q     (sr_q)
  );

  cal_bank #(.WORD_W(WORD_W), .N_CH(N_CH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .wr_stb   (wr_stb),
    .chan_sel (chan_sel),
    .sr_in    (sr_q),
    .words_q  (words_q),
    .commit   (commit)
  );

  cal_addr_guard #(.AW(AW)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .wr_stb     (wr_stb),
    .chan_sel   (chan_sel),
    .in_window  (in_window),
    .addr_moved (addr_moved),
    .addr_err   (addr_err)
  );

  assign cal_words = words_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (cal_words == '0) && !addr_err && (sr_q == '0) && !in_window);

  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && addr_moved) |=> addr_err);

endmodule

// File: tb/test_cal_serial_loader.sv
`timescale 1ns/1ps
module test_cal_serial_loader;

  localparam int W = 6;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sdata = 1'b0;
  logic           shift_en = 1'b0;
  logic           wr_stb = 1'b0;
  logic [2:0]     chan_sel = 3'd0;
  logic [N*W-1:0] cal_words;
  logic           addr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_sr;
  logic [W-1:0] exp_w [N];

  cal_serial_loader i_cal_serial_loader (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .shift_en(shift_en),
    .wr_stb(wr_stb), .chan_sel(chan_sel), .cal_words(cal_words), .addr_err(addr_err)
  );

  always #10 clk = ~clk;   // 50 MHz

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] word_of(input logic [N*W-1:0] v, input int k);
    return v[k*W +: W];
  endfunction

  task automatic check_words(input string req);
    for (int k = 0; k < N; k++) begin
      checks++;
      if (word_of(cal_words, k) !== exp_w[k]) begin
        errors++;
        $display("FAIL %s word %0d: actual %h expected %h", req, k, word_of(cal_words, k), exp_w[k]);
      end
    end
  endtask

  task automatic check_err(input string req, input logic exp);
    checks++;
    if (addr_err !== exp) begin
      errors++;
      $display("FAIL %s addr_err: actual %b expected %b", req, addr_err, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0; shift_en = 1'b0; wr_stb = 1'b0; sdata = 1'b0;
    tick; tick;
    rst_n = 1'b1;
    exp_sr = '0;
    for (int k = 0; k < N; k++) exp_w[k] = '0;
  endtask

  task automatic shift_word(input logic [W-1:0] w, input logic [2:0] a);
    chan_sel = a; shift_en = 1'b1;
    for (int i = W-1; i >= 0; i--) begin
      sdata = w[i];
      tick;
      exp_sr = {exp_sr[W-2:0], w[i]};
    end
    shift_en = 1'b0;
  endtask

  task automatic write_to(input logic [2:0] a);
    chan_sel = a; wr_stb = 1'b1;
    tick;
    exp_w[a] = exp_sr;
    wr_stb = 1'b0;
    tick;
  endtask

  // R1: reset state
  task automatic t_reset;
    do_reset;
    check_words("R1");
    check_err("R1", 1'b0);
  endtask

  // R3, R4: MSB-first load and addressed commit
  task automatic t_basic;
    shift_word(6'h2D, 3'd3);
    write_to(3'd3);
    check_words("R3 R4");
    check_err("R10", 1'b0);
  endtask

  // R7: held word committed to more channels
  task automatic t_hold;
    write_to(3'd5);
    write_to(3'd0);
    check_words("R7");
    check_err("R10", 1'b0);
  endtask

  // R2: data ignored with shift low
  task automatic t_gate;
    for (int i = 0; i < 5; i++) begin
      sdata = i[0];
      chan_sel = 3'(i);
      tick;
    end
    write_to(3'd1);
    check_words("R2");
  endtask

  // R5, R10: idle edges, wandering address
  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      sdata = ~i[0];
      chan_sel = 3'(7 - i);
      tick;
    end
    check_words("R5");
    check_err("R10", 1'b0);
  endtask

  // R6: shift beats simultaneous write
  task automatic t_prio;
    shift_word(6'h3F, 3'd6);
    write_to(3'd7);          // address change here would be an error: keep same window? use 6
    exp_w[7] = 6'h3F;
    check_err("R8", 1'b1);   // channel 7 differs from window reference 6
    do_reset;
    shift_word(6'h3F, 3'd6);
    shift_en = 1'b1; wr_stb = 1'b1; sdata = 1'b0;
    tick;
    exp_sr = {exp_sr[W-2:0], 1'b0};
    shift_en = 1'b0; wr_stb = 1'b0;
    check_words("R6");
    write_to(3'd6);
    check_words("R6");
    check_err("R10", 1'b0);
  endtask

  // R10: address move one edge after the window closed
  task automatic t_after_close;
    chan_sel = 3'd2;
    tick;
    check_err("R10", 1'b0);
    write_to(3'd4);          // write with no shift: no window opens
    check_words("R10");
    check_err("R10", 1'b0);
  endtask

  // R11, R9: move on the closing edge, then stickiness
  task automatic t_close_edge;
    shift_word(6'h15, 3'd4);
    chan_sel = 3'd4; wr_stb = 1'b1;
    tick;
    exp_w[4] = exp_sr;
    wr_stb = 1'b0; chan_sel = 3'd2;
    tick;
    check_err("R11", 1'b1);
    check_words("R4");
    for (int i = 0; i < 8; i++) begin
      chan_sel = 3'd2;
      tick;
    end
    check_err("R9", 1'b1);
  endtask

  // R1: reset clears flag and shift register
  task automatic t_reset_clear;
    do_reset;
    check_err("R1", 1'b0);
    check_words("R1");
    write_to(3'd2);
    check_words("R1");
  endtask

  // R8: address moves mid-shift
  task automatic t_mid;
    chan_sel = 3'd1; shift_en = 1'b1;
    for (int i = 0; i < W; i++) begin
      sdata = 1'b1;
      if (i == 3) chan_sel = 3'd0;
      tick;
    end
    shift_en = 1'b0;
    check_err("R8", 1'b1);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_hold;
    t_gate;
    t_idle;
    t_prio;
    t_after_close;
    t_close_edge;
    t_reset_clear;
    t_mid;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule